// File: doc/BRIEF.md
# SPI Target with Byte FIFOs

This block is the device side of an SPI link. Bytes shifted in on MOSI are written into a receive buffer. Bytes shifted out on MISO are taken from a transmit buffer. Each buffer holds `DEPTH` bytes, 1024 by default. The serial side owns the receive write pointer and the transmit read pointer. A host register port owns the receive read pointer and the transmit write pointer. The host port also holds the clocking mode, the bit orders, the FIFO enables and resets, a level threshold, interrupt enables, the idle byte and a status word.

Every pointer carries one bit more than the buffer index. Equal pointers mean empty. Pointers that differ only in the top bit mean full. The host fills the transmit buffer one 32-bit word at a time, and it reads received bytes through a window. SCLK, CS_n and MOSI are sampled with the system clock, so SCLK must be several times slower than `clk`. An edge on SCLK is recognised about three system clocks after it occurs.

Top module: `spi_target_fifo`

Register map. `hs_addr` has 11 bits. The top two bits are 00 for registers, and the register index sits in bits 3..0. The top two bits are 01 for the transmit word window, with the word index in bits 7..0. The top bit is 1 for the receive byte window, with the byte index in bits 9..0.

| Index | Register | Use |
|---|---|---|
| 0 | CTRL | bit0 CPHA, bit1 CPOL, bit2 transmit MSB-first, bit3 receive MSB-first |
| 1 | FIFOCTL | see R9 |
| 2 | RXW | receive write pointer, read only |
| 3 | RXR | receive read pointer |
| 4 | TXW | transmit write pointer |
| 5 | TXR | transmit read pointer, read only |
| 6 | THR | level threshold |
| 7 | IEN | bit0 level interrupt enable, bit1 deselect interrupt enable |
| 8 | STAT | status bits, see R5, R6, R7 and R10 |
| 9 | CLR | write 1 to clear a sticky status bit |
| 10 | IDLE | byte sent on MISO when no data is available |

## Requirements
- R1: After reset the block reads as follows. Both FIFOs are disabled, every pointer is 0, THR is 8 and IDLE is 0xFF. CTRL reads 0xC, STAT reads 0x14, and both interrupts are low.
- R2: While receive is enabled, each completed byte is stored in the receive buffer at the slot given by the low 10 bits of RXW. RXW then advances by one. CTRL bit3 set to 1 means the first bit on the line is the MSB.
- R3: A word written to the transmit window supplies four bytes. Byte n of the word is bits 8n+7..8n, and byte 0 is sent first. Each completed byte that came from the FIFO advances TXR by one. CTRL bit2 set to 1 sends MSB first.
- R4: When transmit is disabled, or TXW equals TXR, MISO carries the IDLE byte and TXR does not move.
- R5: Pointers are 11 bits wide. When RXW and RXR differ only in bit 10, the buffer is full. A byte received while the buffer is full is dropped, RXW does not move, and STAT bit3 is set. STAT bit3 stays set until a 1 is written to CLR bit3.
- R6: irq_rx is high exactly while IEN bit0 is set and (RXW − RXR) mod 2048 is at least THR. STAT bit0 shows the same level comparison without the enable.
- R7: A rise of CS_n sets STAT bit1, which stays set until a 1 is written to CLR bit1. irq_cs is STAT bit1 gated by IEN bit1.
- R8: If CS_n rises before a byte is complete, the partial bits are discarded. The next transaction starts a fresh byte, and neither RXW nor TXR moves.
- R9: Writing FIFOCTL acts on the transmit FIFO through bits 0..2: bit0 resets its pointers, bit1 enables it and bit2 disables it. Bits 3..5 do the same for the receive FIFO: bit3 resets, bit4 enables and bit5 disables. Disable wins over enable. Reset clears the pointers and reads back as 0. Reading FIFOCTL returns the two enables in bit1 (transmit) and bit4 (receive).
- R10: STAT bit2 is high while the transmit FIFO is empty. STAT bit4 shows the synchronised level of CS_n.
- R11: All four combinations of CPOL and CPHA transfer data correctly in both directions. CPHA=0 samples on the leading edge and CPHA=1 on the trailing edge. CPOL sets the idle level of SCLK.
- R12: While receive is disabled, bytes are discarded and RXW does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | SPI clock from the controller |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| hs_we | input | 1 | Host write strobe |
| hs_addr | input | 11 | Host word address |
| hs_wdata | input | 32 | Host write data |
| hs_rdata | output | 32 | Host read data, combinational from the address |
| irq_rx | output | 1 | Receive level interrupt |
| irq_cs | output | 1 | Chip-select-release interrupt |

## Verification
Each SCLK edge passes through two synchroniser stages and an edge detector. A received bit therefore updates the bit counter, and MISO moves to the next bit, about three system clocks after the edge. A byte moves its pointer in that same cycle, and the next transmit byte is loaded one cycle later. The bench holds every SCLK phase for four system clocks, so each MISO bit is settled before the controller model samples it. After each CS_n release the bench waits eight clocks before it reads pointers and status. Register reads are combinational, so each is sampled one time step after a falling clock edge, following the write that preceded it.

// File: rtl/spi_target_fifo.sv
module spi_target_fifo #(
  parameter int DEPTH = 1024,
  parameter int THR_INIT = 8,
  parameter logic [7:0] IDLE_INIT = 8'hFF,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  input  logic          hs_we,
  input  logic [AW:0]   hs_addr,
  input  logic [31:0]   hs_wdata,
  output logic [31:0]   hs_rdata,
  output logic          irq_rx,
  output logic          irq_cs
);
  localparam int PW = AW + 1;

  logic [7:0]  rx_mem [DEPTH];
  logic [31:0] tx_mem [DEPTH/4];

  logic [2:0] sck_s, cs_s;
  logic [1:0] mo_s;
  logic [3:0] ctrl;
  logic       tx_en, rx_en, cs_evt, rx_ovf, tx_real, reload;
  logic [PW-1:0] rx_wptr, rx_rptr, tx_wptr, tx_rptr, rx_thr;
  logic [1:0] ien;
  logic [7:0] idle, rx_sr, tx_byte;
  logic [2:0] bitcnt;

  wire cpha = ctrl[0];
  wire cpol = ctrl[1];
  wire tx_msb = ctrl[2];
  wire rx_msb = ctrl[3];

  wire cs_act  = ~cs_s[1];
  wire cs_rise = cs_s[1] & ~cs_s[2];
  wire samp    = cs_act && (sck_s[1] != sck_s[2]) && (sck_s[1] == ~(cpol ^ cpha));
  wire mo      = mo_s[1];

  wire [7:0] rx_nxt = rx_msb ? {rx_sr[6:0], mo} : {mo, rx_sr[7:1]};
  wire byte_done = samp && (bitcnt == 3'd7);
  wire [PW-1:0] rx_occ = rx_wptr - rx_rptr;
  wire rx_full  = (rx_wptr ^ rx_rptr) == PW'(DEPTH);
  wire rx_lvl   = rx_occ >= rx_thr;
  wire rx_push  = byte_done && rx_en && !rx_full;
  wire tx_empty = tx_wptr == tx_rptr;
  wire tx_avail = tx_en && !tx_empty;
  wire [31:0] tx_word = tx_mem[tx_rptr[AW-1:2]];
  wire [7:0] tx_head = tx_word[{tx_rptr[1:0], 3'b000} +: 8];

  wire reg_sel = hs_addr[AW:AW-1] == 2'b00;
  wire tx_sel  = hs_addr[AW:AW-1] == 2'b01;
  wire [3:0] ridx = hs_addr[3:0];
  wire reg_wr  = hs_we && reg_sel;
  wire fc_wr   = reg_wr && ridx == 4'd1;
  wire clr_wr  = reg_wr && ridx == 4'd9;
  wire tx_rst_p = fc_wr && hs_wdata[0];
  wire rx_rst_p = fc_wr && hs_wdata[3];

  assign miso   = tx_byte[tx_msb ? 3'd7 - bitcnt : bitcnt];
  assign irq_rx = ien[0] && rx_lvl;
  assign irq_cs = ien[1] && cs_evt;

  always_ff @(posedge clk) begin
    if (hs_we && tx_sel) tx_mem[hs_addr[AW-3:0]] <= hs_wdata;
    if (rx_push) rx_mem[rx_wptr[AW-1:0]] <= rx_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; cs_s <= '1; mo_s <= '0;
      ctrl <= 4'hC; tx_en <= 1'b0; rx_en <= 1'b0;
      rx_wptr <= '0; rx_rptr <= '0; tx_wptr <= '0; tx_rptr <= '0;
      rx_thr <= PW'(THR_INIT); ien <= '0; idle <= IDLE_INIT;
      cs_evt <= 1'b0; rx_ovf <= 1'b0;
      bitcnt <= '0; rx_sr <= '0; tx_byte <= IDLE_INIT; tx_real <= 1'b0; reload <= 1'b0;
    end else begin
      sck_s <= {sck_s[1:0], sclk};
      cs_s  <= {cs_s[1:0], cs_n};
      mo_s  <= {mo_s[0], mosi};
      if (reg_wr) begin
        case (ridx)
          4'd0: ctrl <= hs_wdata[3:0];
          4'd3: rx_rptr <= hs_wdata[PW-1:0];
          4'd4: tx_wptr <= hs_wdata[PW-1:0];
          4'd6: rx_thr <= hs_wdata[PW-1:0];
          4'd7: ien <= hs_wdata[1:0];
          4'd10: idle <= hs_wdata[7:0];
          default: ;
        endcase
      end
      if (fc_wr) begin
        if (hs_wdata[2]) tx_en <= 1'b0; else if (hs_wdata[1]) tx_en <= 1'b1;
        if (hs_wdata[5]) rx_en <= 1'b0; else if (hs_wdata[4]) rx_en <= 1'b1;
      end
      if (rx_rst_p) begin
        rx_wptr <= '0; rx_rptr <= '0;
      end else if (rx_push) rx_wptr <= rx_wptr + PW'(1);
      if (tx_rst_p) begin
        tx_wptr <= '0; tx_rptr <= '0;
      end else if (byte_done && tx_real) tx_rptr <= tx_rptr + PW'(1);
      if (cs_rise) cs_evt <= 1'b1;
      else if (clr_wr && hs_wdata[1]) cs_evt <= 1'b0;
      if (byte_done && rx_en && rx_full) rx_ovf <= 1'b1;
      else if (clr_wr && hs_wdata[3]) rx_ovf <= 1'b0;
      if (!cs_act) bitcnt <= '0;
      else if (samp) bitcnt <= bitcnt + 3'd1;
      if (samp) rx_sr <= rx_nxt;
      reload <= byte_done;
      if (!cs_act || reload) begin
        tx_byte <= tx_avail ? tx_head : idle;
        tx_real <= tx_avail;
      end
    end
  end

  always_comb begin
    hs_rdata = '0;
    if (hs_addr[AW]) hs_rdata = {24'b0, rx_mem[hs_addr[AW-1:0]]};
    else if (reg_sel) begin
      case (ridx)
        4'd0: hs_rdata = {28'b0, ctrl};
        4'd1: hs_rdata = {26'b0, 1'b0, rx_en, 2'b0, tx_en, 1'b0};
        4'd2: hs_rdata = 32'(rx_wptr);
        4'd3: hs_rdata = 32'(rx_rptr);
        4'd4: hs_rdata = 32'(tx_wptr);
        4'd5: hs_rdata = 32'(tx_rptr);
        4'd6: hs_rdata = 32'(rx_thr);
        4'd7: hs_rdata = {30'b0, ien};
        4'd8: hs_rdata = {27'b0, cs_s[1], rx_ovf, tx_empty, cs_evt, rx_lvl};
        4'd10: hs_rdata = {24'b0, idle};
        default: hs_rdata = '0;
      endcase
    end
  end

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && rx_en && rx_full && !rx_rst_p) |=> ($stable(rx_wptr) && rx_ovf)); // R5
  AST_RX_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_rst_p) |=> $stable(rx_wptr)); // R12
  AST_ABORT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !rx_rst_p) |=> (bitcnt == 3'd0 && $stable(rx_wptr))); // R8
  AST_TXR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_rptr == $past(tx_rptr) || tx_rptr == $past(tx_rptr) + PW'(1) || tx_rptr == '0)); // R3
  AST_CS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_evt && !(clr_wr && hs_wdata[1])) |=> cs_evt); // R7
endmodule

// File: tb/spi_target_fifo_test.sv
module spi_target_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, hs_we = 1'b0;
  logic [10:0] hs_addr = '0;
  logic [31:0] hs_wdata = '0;
  logic miso, irq_rx, irq_cs;
  logic [31:0] hs_rdata;

  int nchk = 0, nbad = 0;
  int H = 4;
  bit done = 0;
  logic m_cpol = 0, m_cpha = 0, m_rxmsb = 1, m_txmsb = 1;
  logic [7:0] expq[$];
  string mtag = "R3";

  always #5 clk = ~clk;

  spi_target_fifo uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .hs_we(hs_we), .hs_addr(hs_addr), .hs_wdata(hs_wdata),
    .hs_rdata(hs_rdata), .irq_rx(irq_rx), .irq_cs(irq_cs));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: assembles MISO bytes at the controller's sampling edge, pops expected
  int mcnt = 0;
  logic [7:0] mbits = '0;
  logic last_sclk = 1'b0;
  always @(sclk or cs_n) begin
    if (cs_n) mcnt = 0;
    else if (sclk !== last_sclk && sclk == ~(m_cpol ^ m_cpha)) begin
      mbits = m_txmsb ? {mbits[6:0], miso} : {miso, mbits[7:1]};
      mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        if (expq.size() == 0) check({mtag, " miso (no expected byte)"}, {24'b0, mbits}, 32'hxxxx);
        else check({mtag, " miso"}, {24'b0, mbits}, {24'b0, expq.pop_front()});
      end
    end
    last_sclk = sclk;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    hs_addr = a; hs_wdata = d; hs_we = 1'b1;
    @(negedge clk);
    hs_we = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    hs_addr = a;
    #1 d = hs_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [10:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  function automatic logic [10:0] txw(input int i);
    return {2'b01, 9'(i)};
  endfunction

  function automatic logic [10:0] rxb(input int i);
    return {1'b1, 10'(i)};
  endfunction

  task automatic set_mode(input int m, input logic rxm, input logic txm);
    m_cpha = m[0]; m_cpol = m[1]; m_rxmsb = rxm; m_txmsb = txm;
    wr(11'd0, {28'b0, rxm, txm, m_cpol, m_cpha});
    sclk = m_cpol;
    waitc(6);
  endtask

  task automatic cs_on();
    sclk = m_cpol; cs_n = 1'b0;
    waitc(H);
  endtask

  task automatic cs_off();
    waitc(H);
    cs_n = 1'b1;
    waitc(8);
  endtask

  task automatic xfer(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      if (!m_cpha) begin
        mosi = m_rxmsb ? b[7-i] : b[i];
        waitc(H); sclk = ~m_cpol;
        waitc(H); sclk = m_cpol;
      end else begin
        sclk = ~m_cpol;
        mosi = m_rxmsb ? b[7-i] : b[i];
        waitc(H); sclk = m_cpol;
        waitc(H);
      end
    end
  endtask

  // driver: pushes the expected MISO byte, then shifts the MOSI byte
  task automatic send(input logic [7:0] mo, input logic [7:0] exp_mi);
    expq.push_back(exp_mi);
    xfer(mo, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int W = 0, twp = 0;
    logic [7:0] mb [4];
    logic [7:0] tb [4];
    waitc(3);
    rst_n = 1'b1;
    waitc(2);

    // R1 reset state
    rdchk("R1 fifoctl", 11'd1, 32'h0);
    rdchk("R1 rxw", 11'd2, 32'h0);
    rdchk("R1 txr", 11'd5, 32'h0);
    rdchk("R1 thr", 11'd6, 32'd8);
    rdchk("R1 idle", 11'd10, 32'hFF);
    rdchk("R1 ctrl", 11'd0, 32'hC);
    rdchk("R1 stat", 11'd8, 32'h14);
    check("R1 irqs", {30'b0, irq_rx, irq_cs}, 32'h0);

    // R9 enables
    wr(11'd1, 32'h12);
    rdchk("R9 enables readback", 11'd1, 32'h12);
    wr(11'd7, 32'h3);

    // R2 R3 R4 mode 0, MSB first
    wr(txw(0), 32'h44332211); twp = 4;
    wr(11'd4, twp);
    cs_on();
    rd(11'd8, d);
    check("R10 cs level low", {31'b0, d[4]}, 32'h0);
    mtag = "R3";
    send(8'hA5, 8'h11); send(8'h3C, 8'h22); send(8'h0F, 8'h33); send(8'h81, 8'h44);
    mtag = "R4";
    send(8'h7E, 8'hFF); send(8'hC3, 8'hFF);
    cs_off();
    rdchk("R4 txr stops", 11'd5, 32'd4);
    rdchk("R2 rxw", 11'd2, 32'd6);
    rdchk("R2 byte0", rxb(0), 32'hA5);
    rdchk("R2 byte3", rxb(3), 32'h81);
    rdchk("R2 byte5", rxb(5), 32'hC3);
    rdchk("R7 R10 stat", 11'd8, 32'h16);
    check("R7 irq_cs set", {31'b0, irq_cs}, 32'h1);
    check("R6 below threshold", {31'b0, irq_rx}, 32'h0);
    wr(11'd6, 32'd6);
    check("R6 at threshold", {31'b0, irq_rx}, 32'h1);
    wr(11'd6, 32'd7);
    check("R6 under threshold", {31'b0, irq_rx}, 32'h0);
    wr(11'd9, 32'h2);
    check("R7 cleared", {31'b0, irq_cs}, 32'h0);
    rdchk("R7 stat cleared", 11'd8, 32'h14);
    W = 6; wr(11'd3, W);

    // R11 other clock modes and bit orders
    for (int m = 1; m < 4; m++) begin
      set_mode(m, (m == 3), (m == 2));
      for (int i = 0; i < 4; i++) begin
        tb[i] = 8'(m * 16 + i + 1);
        mb[i] = 8'(8'h96 ^ 8'(m * 37 + i * 11));
      end
      wr(txw(twp / 4), {tb[3], tb[2], tb[1], tb[0]}); twp += 4;
      wr(11'd4, twp);
      mtag = "R11";
      cs_on();
      for (int i = 0; i < 4; i++) send(mb[i], tb[i]);
      cs_off();
      rdchk("R11 rxw", 11'd2, 32'(W + 4));
      for (int i = 0; i < 4; i++) rdchk("R11 rx byte", rxb(W + i), {24'b0, mb[i]});
      rdchk("R11 txr", 11'd5, 32'(twp));
      W += 4; wr(11'd3, W);
      wr(11'd9, 32'h2);
    end
    set_mode(0, 1'b1, 1'b1);

    // R8 partial byte
    cs_on();
    xfer(8'hF0, 5);
    cs_off();
    rdchk("R8 rxw unchanged", 11'd2, 32'(W));
    cs_on();
    mtag = "R8";
    send(8'h69, 8'hFF);
    cs_off();
    rdchk("R8 rxw after clean byte", 11'd2, 32'(W + 1));
    rdchk("R8 clean byte", rxb(W), 32'h69);
    W += 1; wr(11'd3, W);

    // R4 transmit disabled
    wr(11'd10, 32'h5A);
    wr(txw(twp / 4), 32'h0D0C0B0A); twp += 4;
    wr(11'd4, twp);
    wr(11'd1, 32'h04);
    rdchk("R9 tx disable", 11'd1, 32'h10);
    rd(11'd8, d);
    check("R10 tx not empty", {31'b0, d[2]}, 32'h0);
    mtag = "R4";
    cs_on(); send(8'h11, 8'h5A); cs_off();
    rdchk("R4 txr held while disabled", 11'd5, 32'(twp - 4));
    wr(11'd1, 32'h02);
    mtag = "R3";
    cs_on(); send(8'h12, 8'h0A); send(8'h13, 8'h0B); cs_off();
    rdchk("R3 txr two bytes", 11'd5, 32'(twp - 2));
    W += 3; wr(11'd3, W);
    wr(11'd1, 32'h01);
    rdchk("R9 tx reset txr", 11'd5, 32'h0);
    rdchk("R9 tx reset txw", 11'd4, 32'h0);
    rdchk("R9 reset bit self clears", 11'd1, 32'h12);
    twp = 0;

    // R12 receive disabled
    wr(11'd1, 32'h20);
    rdchk("R9 rx disable", 11'd1, 32'h02);
    mtag = "R12";
    cs_on(); send(8'h77, 8'h5A); cs_off();
    rdchk("R12 rxw unchanged", 11'd2, 32'(W));
    wr(11'd1, 32'h10);

    // R5 full and overflow
    wr(11'd3, (W + 2 - 1024) & 2047);
    rd(11'd8, d);
    check("R5 no overflow yet", {31'b0, d[3]}, 32'h0);
    mtag = "R5";
    cs_on(); send(8'hC1, 8'h5A); send(8'hC2, 8'h5A); send(8'hC3, 8'h5A); cs_off();
    rdchk("R5 rxw stops at full", 11'd2, 32'((W + 2) & 2047));
    rd(11'd2, d); rd(11'd3, d2);
    check("R5 full pointers differ in bit10", d ^ d2, 32'h400);
    rd(11'd8, d);
    check("R5 overflow flag", {31'b0, d[3]}, 32'h1);
    rdchk("R5 last stored", rxb((W + 1) & 1023), 32'hC2);
    rdchk("R5 first stored", rxb(W & 1023), 32'hC1);
    check("R6 irq at full", {31'b0, irq_rx}, 32'h1);
    wr(11'd9, 32'h8);
    rd(11'd8, d);
    check("R5 overflow cleared", {31'b0, d[3]}, 32'h0);
    wr(11'd1, 32'h08);
    rdchk("R9 rx reset rxw", 11'd2, 32'h0);
    rdchk("R9 rx reset rxr", 11'd3, 32'h0);
    rdchk("R9 rx still enabled", 11'd1, 32'h12);
    check("R6 irq after reset", {31'b0, irq_rx}, 32'h0);
    check("R3 scoreboard drained", 32'(expq.size()), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule